// File: doc/BRIEF.md
# SPI Host Register Front End

This block sits between a processor's register bus and a command-driven SPI sequencer. Software loads 16-bit commands into a command queue and transmit bytes into a transmit queue, then drains received bytes from a receive queue. It can either pop the head byte or peek at it without removing it. Software watches the fill levels of all three queues through room and level registers. It sees four interrupt causes: each queue nearing its service threshold, and a sync event raised by the sequencer when it reaches a marker in the command stream. Each sync event carries an 8-bit tag that software can read back.

The bus is a simple single-cycle port that accepts one access per cycle. Addresses are byte offsets of 32-bit words. Read data is registered and appears one cycle after the access. A soft-reset register holds the sequencer and all three queues in reset. The block leaves reset in that held state, so software must release it before use.

Top module: `spi_host_regs`

## Requirements
- R1: A read of offset 0x00 returns an identification word with major revision 1 in bits [23:16], minor revision 0 in bits [15:8] and patch 0x61 in bits [7:0], i.e. 0x0001_0061. Unmapped offsets read 0.
- R2: The soft-reset register at 0x40 reads 1 after power-on reset. While it holds 1, `core_rst` is high, all three queues are emptied and pushes into them are dropped. Writing 0 releases it.
- R3: The interrupt bits are numbered bit 0 for command queue low, bit 1 for transmit queue low, bit 2 for receive queue high and bit 3 for sync. The enable mask is at 0x80. Offset 0x84 reads the pending bits ANDed with the enable mask, and 0x88 reads the raw pending bits. `irq` is high when any pending bit is also enabled.
- R4: Writing 1s to 0x84 clears those pending bits. If a set condition for a bit occurs in the same cycle, the set wins.
- R5: The command and transmit low bits are set every cycle in which their queue holds 4 or fewer entries. The receive high bit is set every cycle in which the receive queue holds 12 or more entries.
- R6: A `sync_valid` pulse stores `sync_id_in` into the tag register at 0xC0 and sets pending bit 3.
- R7: A write to 0xE0 pushes `bus_wdata[15:0]` into the 16-entry command queue. The sequencer receives the entries in write order on `cmd_data` and pops them with `cmd_ready`. Offset 0xD0 reads 16 minus the fill level.
- R8: A write to 0xE4 pushes `bus_wdata[7:0]` into the 16-entry transmit queue, which the sequencer drains in order through `tx_ready`. Offset 0xD4 reads the free room.
- R9: The sequencer pushes received bytes with `rx_valid`, and `rx_ready` is low when the receive queue is full. Offset 0xD8 reads the fill level. A read of 0xE8 returns the head byte zero-extended and pops it. A read of 0xEC returns the head byte without popping it.
- R10: A read of 0xE8 or 0xEC on an empty receive queue returns 0 and leaves the level at 0. Pushes into any full queue are dropped.
- R11: Read data appears on `bus_rdata` in the cycle after the read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_rst | output | 1 | Soft reset to the sequencer |
| cmd_valid | output | 1 | Command queue not empty |
| cmd_data | output | 16 | Head command |
| cmd_ready | input | 1 | Sequencer pops a command |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_data | output | 8 | Head transmit byte |
| tx_ready | input | 1 | Sequencer pops a transmit byte |
| rx_valid | input | 1 | Sequencer pushes a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive queue has room |
| sync_valid | input | 1 | Sync marker reached |
| sync_id_in | input | 8 | Tag of the sync marker |
| irq | output | 1 | Level interrupt |

## Verification
Two events can land on the same cycle: a sync event from the sequencer and a software write that clears pending bit 3. The bench first clears the bit, then drives the clearing write and a `sync_valid` pulse with a new tag at the same clock edge. It expects bit 3 to read back set in the raw source register and the new tag to read back at 0xC0. The same priority governs the queue watermark bits: a clear issued while a queue is still below its threshold must not stick. The bench checks this with an empty command queue, then again after the queue has been filled above the threshold.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int NUM_IRQ = 4;

    // interrupt bit positions (software decodes them)
    localparam int IRQ_CMD_LOW  = 0;
    localparam int IRQ_TX_LOW   = 1;
    localparam int IRQ_RX_HIGH  = 2;
    localparam int IRQ_SYNC     = 3;

    // register offsets
    localparam logic [7:0] OFS_VERSION  = 8'h00;
    localparam logic [7:0] OFS_SRST     = 8'h40;
    localparam logic [7:0] OFS_IRQ_EN   = 8'h80;
    localparam logic [7:0] OFS_IRQ_PEND = 8'h84;
    localparam logic [7:0] OFS_IRQ_SRC  = 8'h88;
    localparam logic [7:0] OFS_SYNC_TAG = 8'hC0;
    localparam logic [7:0] OFS_CMD_ROOM = 8'hD0;
    localparam logic [7:0] OFS_TX_ROOM  = 8'hD4;
    localparam logic [7:0] OFS_RX_LVL   = 8'hD8;
    localparam logic [7:0] OFS_CMD_PUSH = 8'hE0;
    localparam logic [7:0] OFS_TX_PUSH  = 8'hE4;
    localparam logic [7:0] OFS_RX_POP   = 8'hE8;
    localparam logic [7:0] OFS_RX_PEEK  = 8'hEC;

    typedef struct packed {
        logic                    srst;
        logic [NUM_IRQ-1:0]      enable;
        logic [7:0]              sync_tag;
        logic [31:0]             rdata;
    } regs_t;

endpackage

// File: rtl/fifo_buf.sv
module fifo_buf #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fst_t;

    fst_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == FULL_CNT);
    assign count = st_q.cnt;
    assign head  = mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
        if (do_push) st_d.wp = (st_q.wp == LAST_PTR) ? '0 : st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = (st_q.rp == LAST_PTR) ? '0 : st_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= wdata;
    end

    // R10
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count)));

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> (count == '0));

    // R2
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] enable,
    output logic [N-1:0] pending,
    output logic         irq
);

    logic [N-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = (pend_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q;
    assign irq     = |(pend_q & enable);

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((pending & $past(set_vec)) == $past(set_vec)));

    // R4
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((pending & $past(clr_vec & ~set_vec)) == '0));

    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int          DEPTH     = 16,
    parameter int          CMD_W     = 16,
    parameter int          DAT_W     = 8,
    parameter int          LOW_MARK  = 4,
    parameter int          HIGH_MARK = 12,
    parameter logic [7:0]  VER_MAJOR = 8'd1,
    parameter logic [7:0]  VER_MINOR = 8'd0,
    parameter logic [7:0]  VER_PATCH = 8'h61
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             core_rst,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_data,
    input  logic             cmd_ready,
    output logic             tx_valid,
    output logic [DAT_W-1:0] tx_data,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [DAT_W-1:0] rx_data,
    output logic             rx_ready,
    input  logic             sync_valid,
    input  logic [7:0]       sync_id_in,
    output logic             irq
);

    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] LOW_L  = LVL_W'(LOW_MARK);
    localparam logic [LVL_W-1:0] HIGH_L = LVL_W'(HIGH_MARK);

    regs_t r_d, r_q;

    logic wr_acc, rd_acc;
    logic cmd_push, tx_push, rx_pop;
    logic [LVL_W-1:0] cmd_lvl, tx_lvl, rx_lvl;
    logic cmd_empty, tx_empty, rx_empty;
    logic cmd_full, tx_full, rx_full;
    logic [DAT_W-1:0] rx_head;
    logic [NUM_IRQ-1:0] set_vec, clr_vec, pending;
    logic [31:0] rd_val;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata[31:CMD_W];

    assign wr_acc   = bus_sel && bus_wr;
    assign rd_acc   = bus_sel && !bus_wr;
    assign cmd_push = wr_acc && (bus_addr == OFS_CMD_PUSH);
    assign tx_push  = wr_acc && (bus_addr == OFS_TX_PUSH);
    assign rx_pop   = rd_acc && (bus_addr == OFS_RX_POP);

    fifo_buf #(.W(CMD_W), .DEPTH(DEPTH)) u_cmd_q (
        .clk(clk), .rst_n(rst_n), .clr(r_q.srst),
        .push(cmd_push), .wdata(bus_wdata[CMD_W-1:0]), .pop(cmd_ready),
        .head(cmd_data), .count(cmd_lvl), .empty(cmd_empty), .full(cmd_full)
    );

    fifo_buf #(.W(DAT_W), .DEPTH(DEPTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .clr(r_q.srst),
        .push(tx_push), .wdata(bus_wdata[DAT_W-1:0]), .pop(tx_ready),
        .head(tx_data), .count(tx_lvl), .empty(tx_empty), .full(tx_full)
    );

    fifo_buf #(.W(DAT_W), .DEPTH(DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .clr(r_q.srst),
        .push(rx_valid), .wdata(rx_data), .pop(rx_pop),
        .head(rx_head), .count(rx_lvl), .empty(rx_empty), .full(rx_full)
    );

    assign cmd_valid = !cmd_empty;
    assign tx_valid  = !tx_empty;
    assign rx_ready  = !rx_full && !r_q.srst;
    assign core_rst  = r_q.srst;

    always_comb begin
        set_vec              = '0;
        set_vec[IRQ_CMD_LOW] = (cmd_lvl <= LOW_L);
        set_vec[IRQ_TX_LOW]  = (tx_lvl  <= LOW_L);
        set_vec[IRQ_RX_HIGH] = (rx_lvl  >= HIGH_L);
        set_vec[IRQ_SYNC]    = sync_valid;
        clr_vec = (wr_acc && bus_addr == OFS_IRQ_PEND) ? bus_wdata[NUM_IRQ-1:0] : '0;
    end

    irq_unit #(.N(NUM_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .enable(r_q.enable), .pending(pending), .irq(irq)
    );

    always_comb begin
        case (bus_addr)
            OFS_VERSION:  rd_val = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};
            OFS_SRST:     rd_val = {31'h0, r_q.srst};
            OFS_IRQ_EN:   rd_val = 32'(r_q.enable);
            OFS_IRQ_PEND: rd_val = 32'(pending & r_q.enable);
            OFS_IRQ_SRC:  rd_val = 32'(pending);
            OFS_SYNC_TAG: rd_val = 32'(r_q.sync_tag);
            OFS_CMD_ROOM: rd_val = 32'(DEPTH) - 32'(cmd_lvl);
            OFS_TX_ROOM:  rd_val = 32'(DEPTH) - 32'(tx_lvl);
            OFS_RX_LVL:   rd_val = 32'(rx_lvl);
            OFS_RX_POP,
            OFS_RX_PEEK:  rd_val = rx_empty ? 32'h0 : 32'(rx_head);
            default:      rd_val = 32'h0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (wr_acc && bus_addr == OFS_SRST)   r_d.srst   = bus_wdata[0];
        if (wr_acc && bus_addr == OFS_IRQ_EN) r_d.enable = bus_wdata[NUM_IRQ-1:0];
        if (sync_valid)                       r_d.sync_tag = sync_id_in;
        if (rd_acc)                           r_d.rdata  = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.srst <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;

    // R1
    version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && bus_addr == OFS_VERSION) |=> (bus_rdata[23:16] == VER_MAJOR));

    // R6
    sync_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid |=> (r_q.sync_tag == $past(sync_id_in)) && pending[IRQ_SYNC]);

    // R10
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |=> (bus_rdata == 32'h0));

    // R2
    srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst && $past(core_rst)) |-> (cmd_empty && tx_empty && rx_empty));

endmodule

// File: tb/spi_host_regs_test.sv
`timescale 1ns/1ps
module spi_host_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_rst;
    logic        cmd_valid;
    logic [15:0] cmd_data;
    logic        cmd_ready = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        sync_valid = 1'b0;
    logic [7:0]  sync_id_in = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_host_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_rst(core_rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .sync_valid(sync_valid), .sync_id_in(sync_id_in),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic test_reset_state();
        logic [31:0] v;
        bus_read(8'h00, v); chk("R1 version", v, 32'h0001_0061);
        bus_read(8'h40, v); chk("R2 srst after reset", v, 32'h1);
        chk("R2 core_rst held", 32'(core_rst), 32'h1);
        bus_read(8'h88, v); chk("R5 empty queues low", v, 32'h3);
        chk("R3 irq masked", 32'(irq), 32'h0);
        bus_read(8'h10, v); chk("R1 unmapped", v, 32'h0);
        bus_write(8'h40, 32'h0);
        @(negedge clk); chk("R2 released", 32'(core_rst), 32'h0);
    endtask

    task automatic test_cmd_queue();
        logic [31:0] v;
        for (int i = 0; i < 17; i++) bus_write(8'hE0, 32'hABCD_1000 + 32'(i));
        bus_read(8'hD0, v); chk("R10 cmd room full", v, 32'h0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk("R7 cmd order", {16'h0, cmd_data}, 32'h1000 + 32'(i));
            cmd_ready = 1'b1;
            @(posedge clk); #1;
            cmd_ready = 1'b0;
        end
        @(negedge clk); chk("R10 cmd 17th dropped", 32'(cmd_valid), 32'h0);
        bus_read(8'hD0, v); chk("R7 cmd room empty", v, 32'd16);
    endtask

    task automatic test_tx_queue();
        logic [31:0] v;
        logic [7:0] exp [3];
        exp[0] = 8'hA5; exp[1] = 8'h3C; exp[2] = 8'hFF;
        bus_write(8'hE4, 32'h1A5); bus_write(8'hE4, 32'h23C); bus_write(8'hE4, 32'h0FF);
        bus_read(8'hD4, v); chk("R8 tx room", v, 32'd13);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 tx order", 32'(tx_data), 32'(exp[i]));
            tx_ready = 1'b1;
            @(posedge clk); #1;
            tx_ready = 1'b0;
        end
        @(negedge clk); chk("R8 tx drained", 32'(tx_valid), 32'h0);
    endtask

    task automatic test_rx_queue();
        logic [31:0] v;
        for (int i = 0; i < 13; i++) rx_push(8'h40 + 8'(i));
        bus_read(8'hD8, v); chk("R9 rx level", v, 32'd13);
        bus_read(8'h88, v); chk("R5 rx high", v & 32'h4, 32'h4);
        bus_read(8'hEC, v); chk("R9 peek value", v, 32'h40);
        bus_read(8'hD8, v); chk("R9 peek keeps level", v, 32'd13);
        bus_read(8'hE8, v); chk("R11 R9 pop value", v, 32'h40);
        bus_read(8'hD8, v); chk("R9 level after pop", v, 32'd12);
        for (int i = 1; i < 13; i++) begin
            bus_read(8'hE8, v); chk("R9 pop order", v, 32'h40 + 32'(i));
        end
        bus_read(8'hE8, v); chk("R10 empty pop", v, 32'h0);
        bus_read(8'hEC, v); chk("R10 empty peek", v, 32'h0);
        bus_read(8'hD8, v); chk("R10 no underflow", v, 32'h0);
    endtask

    task automatic test_rx_full();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) rx_push(8'h80 + 8'(i));
        @(negedge clk); chk("R9 rx_ready low when full", 32'(rx_ready), 32'h0);
        rx_push(8'hEE);
        bus_read(8'hD8, v); chk("R10 rx full drop", v, 32'd16);
    endtask

    task automatic test_sync_irq();
        logic [31:0] v;
        bus_write(8'h80, 32'h8);
        @(negedge clk); chk("R3 irq idle", 32'(irq), 32'h0);
        @(negedge clk);
        sync_valid = 1'b1; sync_id_in = 8'h5C;
        @(posedge clk); #1;
        sync_valid = 1'b0;
        bus_read(8'hC0, v); chk("R6 tag", v, 32'h5C);
        chk("R3 irq raised", 32'(irq), 32'h1);
        bus_read(8'h84, v); chk("R3 masked pending", v, 32'h8);
        bus_write(8'h84, 32'h8);
        bus_read(8'h84, v); chk("R4 w1c", v, 32'h0);
        chk("R3 irq cleared", 32'(irq), 32'h0);
    endtask

    task automatic test_collision();
        logic [31:0] v;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h84; bus_wdata = 32'h8;
        sync_valid = 1'b1; sync_id_in = 8'h77;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; sync_valid = 1'b0;
        bus_read(8'h88, v); chk("R4 set beats clear", v & 32'h8, 32'h8);
        bus_read(8'hC0, v); chk("R6 tag on collision", v, 32'h77);
        bus_write(8'h84, 32'h8);
    endtask

    task automatic test_watermark();
        logic [31:0] v;
        bus_write(8'h80, 32'h1);
        @(negedge clk); chk("R5 cmd low irq", 32'(irq), 32'h1);
        bus_write(8'h84, 32'h1);
        bus_read(8'h88, v); chk("R5 low re-sets", v & 32'h1, 32'h1);
        for (int i = 0; i < 5; i++) bus_write(8'hE0, 32'h2000 + 32'(i));
        bus_write(8'h84, 32'h1);
        bus_read(8'h88, v); chk("R5 low clear sticks", v & 32'h1, 32'h0);
        chk("R3 irq low off", 32'(irq), 32'h0);
    endtask

    task automatic test_soft_reset();
        logic [31:0] v;
        bus_write(8'h40, 32'h1);
        @(negedge clk); chk("R2 core_rst set", 32'(core_rst), 32'h1);
        bus_write(8'hE0, 32'h3333);
        bus_read(8'hD0, v); chk("R2 cmd cleared", v, 32'd16);
        bus_read(8'hD8, v); chk("R2 rx cleared", v, 32'h0);
        bus_write(8'h40, 32'h0);
        bus_read(8'h40, v); chk("R2 release reads 0", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        test_reset_state();
        test_cmd_queue();
        test_tx_queue();
        test_rx_queue();
        test_sync_irq();
        test_collision();
        test_watermark();
        test_rx_full();
        test_soft_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule